// File: doc/BRIEF.md
# Configurable FPGA I/O Cell

This block is one programmable pad cell for the edge of a programmable-logic fabric. Its outgoing side takes a data bit and a three-state enable from the core. Each passes through its own storage stage, which configuration sets to a rising-edge flop, a transparent latch or a plain wire. The enable can be inverted before it reaches the pad driver. Its incoming side returns the pad value to the core through a stage that can be set in the same three ways. An optional one-clock capture stage sits in front of that stage and removes the hold requirement on pad data.

The pad itself is split into pad_out_o, pad_oe_o and pad_in_i, so the cell stays synthesizable. A deasserted pad_oe_o stands for high impedance. The cell also asks the pad for a weak pull-up or pull-down through two control outputs. The pad model outside the cell resolves an undriven pad in this order: an external driver if there is one, then the requested pull, then the last value kept. The configuration is held in two small registers, loaded through an address/data/write-enable port.

Top module: `fpga_io_cell`

## Requirements
- R1: The outgoing data stage follows field out_mode, which is config address 0, bits [1:0]. Value 0 (and the spare value 3) passes core_d_i straight through. Value 1 captures core_d_i on a rising clock edge when out_ce_i is 1. Value 2 is a latch that is transparent while out_ce_i is 1 and holds while it is 0.
- R2: The enable stage follows field oe_mode, which is address 0, bits [3:2]. It uses the same encoding as R1, applied to core_oe_i and gated by out_ce_i.
- R3: Bit 4 of address 0 inverts the output of the enable stage, so pad_oe_o = stage output XOR bit. pad_oe_o = 0 means the pad is not driven (high impedance).
- R4: The incoming stage follows field in_mode, which is address 1, bits [1:0]. It uses the encoding of R1, gated by in_ce_i, and its result appears on core_q_o.
- R5: When address 1, bit 2 is set, the incoming stage is fed the pad value captured on the previous rising edge rather than the live pad value, which adds exactly one clock of latency. The capture happens on every edge.
- R6: Address 1, bits [4:3] select the pull: 1 = pull-down (pad_pd_o = 1), 2 = pull-up (pad_pu_o = 1), 0 or 3 = none. The two outputs are never 1 together. With the pad undriven and no external driver, the core sees the pull value.
- R7: A write with cfg_we_i = 1 loads the field group of the addressed register on the rising edge that accepts it. The outputs change only after that edge. Without a write the configuration holds.
- R8: The flop and the latch of every stage keep running whatever mode is selected. A change of mode therefore shows the value that storage already holds.
- R9: rst_ni low clears all storage and all configuration at once: every stage direct, no inversion, no pull, no delay.
- R10: Writes to addresses 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | CFG_AW | Configuration register select |
| cfg_wdata_i | input | CFG_DW | Configuration write data |
| core_d_i | input | 1 | Outgoing data from the core |
| core_oe_i | input | 1 | Three-state enable from the core |
| out_ce_i | input | 1 | Clock enable / latch gate for the outgoing stages |
| in_ce_i | input | 1 | Clock enable / latch gate for the incoming stage |
| core_q_o | output | 1 | Incoming data to the core |
| pad_out_o | output | 1 | Value for the pad driver |
| pad_oe_o | output | 1 | Pad driver enable (0 = high impedance) |
| pad_in_i | input | 1 | Resolved pad value |
| pad_pu_o | output | 1 | Weak pull-up request |
| pad_pd_o | output | 1 | Weak pull-down request |

## Verification
A configuration write can land in the same cycle as a flop capture on the data, enable and incoming stages. The write applies at the very edge where the old mode's flops take new data. The bench sweeps every mode combination by writing both registers back to back while the stages run with random gates and data. It then judges the first cycles after each write against a reference that applies the new fields only after the edge. In the same way, a delayed input capture coincides with the pad changing at that edge in flop output mode. The reference uses the pre-edge pad value for both the delay stage and the incoming flop.

// File: rtl/fpga_io_pkg.sv
package fpga_io_pkg;

  typedef enum logic [1:0] {
    PATH_DIRECT = 2'd0,
    PATH_FLOP   = 2'd1,
    PATH_LATCH  = 2'd2,
    PATH_SPARE  = 2'd3
  } path_mode_e;

  typedef enum logic [1:0] {
    PULL_NONE  = 2'd0,
    PULL_DOWN  = 2'd1,
    PULL_UP    = 2'd2,
    PULL_NONE2 = 2'd3
  } pull_e;

  typedef struct packed {
    logic       oe_inv;
    path_mode_e oe_mode;
    path_mode_e out_mode;
  } out_cfg_t;

  typedef struct packed {
    pull_e      pull;
    logic       dly_en;
    path_mode_e in_mode;
  } in_cfg_t;

  localparam int unsigned FIELD_W  = 5;
  localparam int unsigned ADDR_OUT = 0;
  localparam int unsigned ADDR_IN  = 1;

endpackage

// File: rtl/io_cfg_regs.sv
module io_cfg_regs
  import fpga_io_pkg::*;
#(
  parameter int unsigned AW = 2,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output out_cfg_t      out_cfg_o,
  output in_cfg_t       in_cfg_o
);

  localparam int unsigned SPARE_W = DW - FIELD_W;

  logic [FIELD_W-1:0] field;
  logic               sel_out, sel_in;

  assign field   = wdata_i[FIELD_W-1:0];
  assign sel_out = we_i && (addr_i == AW'(ADDR_OUT));
  assign sel_in  = we_i && (addr_i == AW'(ADDR_IN));

  generate
    if (SPARE_W > 0) begin : g_spare
      logic unused_spare;
      assign unused_spare = ^wdata_i[DW-1:FIELD_W];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_cfg_o <= '0;
      in_cfg_o  <= '0;
    end else begin
      if (sel_out) out_cfg_o <= out_cfg_t'(field);
      if (sel_in)  in_cfg_o  <= in_cfg_t'(field);
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable({out_cfg_o, in_cfg_o})) else $error("cfg changed without write"); // R7

  AST_CFG_LOAD_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(ADDR_OUT)) |=> (FIELD_W'(out_cfg_o) == $past(wdata_i[FIELD_W-1:0])))
    else $error("out cfg not loaded"); // R7

  AST_CFG_SPARE_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i > AW'(ADDR_IN)) |=> $stable({out_cfg_o, in_cfg_o}))
    else $error("spare address changed cfg"); // R10

endmodule

// File: rtl/io_path.sv
module io_path
  import fpga_io_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  path_mode_e mode_i,
  input  logic       ce_i,
  input  logic       d_i,
  output logic       q_o
);

  logic ff_q;
  logic lat_q;

  // Both storage elements run in every mode; the mode only picks the tap.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ff_q <= 1'b0;
    else if (ce_i) ff_q <= d_i;
  end

  always_latch begin
    if (!rst_ni)   lat_q = 1'b0;
    else if (ce_i) lat_q = d_i;
  end

  always_comb begin
    unique case (mode_i)
      PATH_FLOP:  q_o = ff_q;
      PATH_LATCH: q_o = lat_q;
      default:    q_o = d_i;
    endcase
  end

  AST_DIRECT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == PATH_DIRECT || mode_i == PATH_SPARE) |-> (q_o == d_i))
    else $error("direct path mismatch"); // R1

  AST_FLOP_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == PATH_FLOP && ce_i) |=> (mode_i != PATH_FLOP || q_o == $past(d_i)))
    else $error("flop did not capture"); // R1

  AST_FLOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == PATH_FLOP && !ce_i) |=> (mode_i != PATH_FLOP || $stable(q_o)))
    else $error("flop changed without enable"); // R1

  AST_LATCH_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == PATH_LATCH && ce_i) |-> (q_o == d_i))
    else $error("open latch not transparent"); // R1

endmodule

// File: rtl/io_in_stage.sv
module io_in_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dly_en_i,
  input  logic pad_i,
  output logic q_o
);

  logic dly_q;

  // Capture stage runs on every edge so enabling it shows a valid value at once.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dly_q <= 1'b0;
    else         dly_q <= pad_i;
  end

  assign q_o = dly_en_i ? dly_q : pad_i;

endmodule

// File: rtl/fpga_io_cell.sv
module fpga_io_cell
  import fpga_io_pkg::*;
#(
  parameter int unsigned CFG_AW = 2,
  parameter int unsigned CFG_DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  input  logic              core_d_i,
  input  logic              core_oe_i,
  input  logic              out_ce_i,
  input  logic              in_ce_i,
  output logic              core_q_o,
  output logic              pad_out_o,
  output logic              pad_oe_o,
  input  logic              pad_in_i,
  output logic              pad_pu_o,
  output logic              pad_pd_o
);

  localparam int unsigned N_OUT = 2;  // data, enable

  out_cfg_t out_cfg;
  in_cfg_t  in_cfg;

  path_mode_e       out_mode [N_OUT];
  logic [N_OUT-1:0] out_d;
  logic [N_OUT-1:0] out_q;
  logic             in_d;

  io_cfg_regs #(
    .AW (CFG_AW),
    .DW (CFG_DW)
  ) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .addr_i    (cfg_addr_i),
    .wdata_i   (cfg_wdata_i),
    .out_cfg_o (out_cfg),
    .in_cfg_o  (in_cfg)
  );

  assign out_mode[0] = out_cfg.out_mode;
  assign out_mode[1] = out_cfg.oe_mode;
  assign out_d       = {core_oe_i, core_d_i};

  generate
    for (genvar g = 0; g < N_OUT; g++) begin : g_out
      io_path u_path (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .mode_i (out_mode[g]),
        .ce_i   (out_ce_i),
        .d_i    (out_d[g]),
        .q_o    (out_q[g])
      );
    end
  endgenerate

  assign pad_out_o = out_q[0];
  assign pad_oe_o  = out_q[1] ^ out_cfg.oe_inv;

  io_in_stage u_in_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dly_en_i (in_cfg.dly_en),
    .pad_i    (pad_in_i),
    .q_o      (in_d)
  );

  io_path u_in_path (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (in_cfg.in_mode),
    .ce_i   (in_ce_i),
    .d_i    (in_d),
    .q_o    (core_q_o)
  );

  assign pad_pu_o = (in_cfg.pull == PULL_UP);
  assign pad_pd_o = (in_cfg.pull == PULL_DOWN);

  AST_PULL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pad_pu_o && pad_pd_o)) else $error("both pulls on"); // R6

  AST_OE_POLARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_cfg.oe_mode == PATH_DIRECT) |-> (pad_oe_o == (core_oe_i ^ out_cfg.oe_inv)))
    else $error("enable polarity wrong"); // R3

  AST_DLY_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_cfg.dly_en && in_cfg.in_mode == PATH_DIRECT) |=>
      (!(in_cfg.dly_en && in_cfg.in_mode == PATH_DIRECT) || core_q_o == $past(pad_in_i)))
    else $error("input delay latency wrong"); // R5

endmodule

// File: tb/fpga_io_cell_bench.sv
module fpga_io_cell_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       core_d = 1'b0, core_oe = 1'b0, out_ce = 1'b0, in_ce = 1'b0;
  logic       pad_in = 1'b0;
  logic       core_q, pad_out, pad_oe, pad_pu, pad_pd;
  logic       ext_en = 1'b0, ext_v = 1'b0;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  fpga_io_cell u_fpga_io_cell (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_we_i    (cfg_we),
    .cfg_addr_i  (cfg_addr),
    .cfg_wdata_i (cfg_wdata),
    .core_d_i    (core_d),
    .core_oe_i   (core_oe),
    .out_ce_i    (out_ce),
    .in_ce_i     (in_ce),
    .core_q_o    (core_q),
    .pad_out_o   (pad_out),
    .pad_oe_o    (pad_oe),
    .pad_in_i    (pad_in),
    .pad_pu_o    (pad_pu),
    .pad_pd_o    (pad_pd)
  );

  // reference state
  logic [1:0] m_out_mode = 0, m_oe_mode = 0, m_in_mode = 0, m_pull = 0;
  logic m_inv = 0, m_dly = 0;
  logic m_d_ff = 0, m_d_lat = 0, m_oe_ff = 0, m_oe_lat = 0, m_i_ff = 0, m_i_lat = 0;
  logic m_dly_q = 0, m_pad = 0, m_keep = 0;
  bit   m_fresh = 0, m_ign = 0;

  function automatic logic pth(logic [1:0] m, logic d, logic ff, logic lat);
    if (m == 2'd1) return ff;
    if (m == 2'd2) return lat;
    return d;
  endfunction

  function automatic logic exp_oe();
    return pth(m_oe_mode, core_oe, m_oe_ff, m_oe_lat) ^ m_inv;
  endfunction

  function automatic logic exp_out();
    return pth(m_out_mode, core_d, m_d_ff, m_d_lat);
  endfunction

  function automatic logic in_d();
    return m_dly ? m_dly_q : m_pad;
  endfunction

  // pad environment: driver, then external source, then pull, then keeper
  task automatic model_pad();
    if (exp_oe())          m_pad = exp_out();
    else if (ext_en)       m_pad = ext_v;
    else if (m_pull == 2)  m_pad = 1'b1;
    else if (m_pull == 1)  m_pad = 1'b0;
    else                   m_pad = m_keep;
    m_keep = m_pad;
  endtask

  task automatic model_comb();
    if (out_ce) begin m_d_lat = core_d; m_oe_lat = core_oe; end
    model_pad();
    if (in_ce) m_i_lat = in_d();
    pad_in = m_pad;
  endtask

  task automatic model_edge();
    logic id;
    id = in_d();
    if (out_ce) begin m_d_ff = core_d; m_oe_ff = core_oe; end
    if (in_ce) m_i_ff = id;
    m_dly_q = m_pad;
    m_fresh = cfg_we && cfg_addr < 2;
    m_ign   = cfg_we && cfg_addr >= 2;
    if (cfg_we && cfg_addr == 0) begin
      m_out_mode = cfg_wdata[1:0]; m_oe_mode = cfg_wdata[3:2]; m_inv = cfg_wdata[4];
    end
    if (cfg_we && cfg_addr == 1) begin
      m_in_mode = cfg_wdata[1:0]; m_dly = cfg_wdata[2]; m_pull = cfg_wdata[4:3];
    end
  endtask

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    string pre;
    pre = m_fresh ? "R7 R8 " : (m_ign ? "R10 " : "");
    chk({pre, "R1 pad_out"}, pad_out, exp_out());
    chk({pre, m_inv ? "R3 pad_oe" : "R2 pad_oe"}, pad_oe, exp_oe());
    chk({pre, m_dly ? "R5 core_q" : "R4 core_q"}, core_q, pth(m_in_mode, in_d(), m_i_ff, m_i_lat));
    chk({pre, "R6 pull_up"}, pad_pu, m_pull == 2);
    chk({pre, "R6 pull_down"}, pad_pd, m_pull == 1);
  endtask

  task automatic step(logic we, logic [1:0] a, logic [7:0] wd);
    @(negedge clk);
    out_ce = ($urandom % 3) != 0;
    in_ce  = ($urandom % 3) != 0;
    #1;
    core_d    = $urandom;
    core_oe   = $urandom;
    ext_en    = ($urandom % 4) == 0;
    ext_v     = $urandom;
    cfg_we    = we;
    cfg_addr  = a;
    cfg_wdata = wd;
    model_comb();
    #3;
    check_all();
    @(posedge clk);
    model_edge();
    #1;
    model_comb();
  endtask

  initial begin
    #(200000 * 20);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R9: reset state, everything direct and no pull
    core_d = 1'b1; core_oe = 1'b0; pad_in = 1'b1;
    #25;
    chk("R9 reset pad_out", pad_out, 1'b1);
    chk("R9 reset pad_oe", pad_oe, 1'b0);
    chk("R9 reset core_q", core_q, 1'b1);
    chk("R9 reset pull", pad_pu | pad_pd, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    m_keep = 1'b1;
    model_comb();

    // directed: pull-up on an undriven pad with no external source (R6)
    step(1'b1, 2'd0, 8'h00);
    step(1'b1, 2'd1, 8'h10);
    @(negedge clk);
    core_oe = 1'b0; ext_en = 1'b0; cfg_we = 1'b0; #1;
    model_comb(); #3;
    chk("R6 undriven pad reads pull-up", core_q, 1'b1);
    @(posedge clk); model_edge(); #1; model_comb();

    // directed: spare address written with all ones (R10)
    step(1'b1, 2'd2, 8'hFF);
    step(1'b1, 2'd3, 8'hFF);
    step(1'b0, 2'd0, 8'h00);

    // sweep every mode combination
    for (int om = 0; om < 3; om++)
      for (int em = 0; em < 3; em++)
        for (int iv = 0; iv < 2; iv++)
          for (int im = 0; im < 3; im++)
            for (int dl = 0; dl < 2; dl++)
              for (int pl = 0; pl < 3; pl++) begin
                step(1'b1, 2'd0, {3'b000, iv[0], em[1:0], om[1:0]});
                step(1'b1, 2'd1, {3'b000, pl[1:0], dl[0], im[1:0]});
                for (int k = 0; k < 4; k++) step(1'b0, 2'd0, 8'h00);
              end

    // random phase including spare codes and spare addresses
    for (int k = 0; k < 400; k++)
      step(($urandom % 5) == 0, 2'($urandom), 8'($urandom));

    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  end

endmodule